// File: doc/BRIEF.md
# Dual-Channel Interrupt and Pin-Change Controller

This block gathers interrupt requests from two serial channels, called A and B, and from a small group of general input pins. It drives a single interrupt line to the processor. Each channel supplies three level requests: transmit, receive and break. The channel logic itself lives elsewhere.

The pins first pass through a two-flop synchroniser. Any level change on a pin whose detection is enabled is held in a sticky change flag. Reading the pin-change register clears all change flags. If any change flag is set, the input-change source bit is raised in the status of both channels. The mask then decides which of the two channels forwards that bit to the interrupt line.

Software sees the status and mask bits in two ways. A combined register packs both channels as two 4-bit nibbles. Per-channel registers show one nibble each in their low bits. Both mask views are backed by one set of flops, so they always agree.

Register access uses a simple strobe bus. A read returns data on `reg_rdata` one clock after the strobe.

Top module: `icc_ctrl`

## Requirements
- R1: After synchronous reset, `irq_out` is 0, the combined mask reads 0x00, the enable register reads 0x00 and all change flags are clear.
- R2: The combined status register (address 0) reads channel A in bits 3:0 and channel B in bits 7:4. Within each nibble, bit 0 is transmit, bit 1 is receive, bit 2 is break and bit 3 is input change.
- R3: The per-channel status registers are address 1 for channel A and address 2 for channel B. Each shows its channel's nibble in bits 3:0, and bits 7:4 read 0.
- R4: The combined mask (address 3) uses the same layout as the combined status register. The channel A mask view (address 4) and the channel B mask view (address 5) read and write bits 3:0 of the same storage. A write through any one view is visible through the others.
- R5: The pin-change register (address 6) returns the synchronised pin levels in bits 3:0 and the change flags in bits 7:4, with pin n at bit n and bit n+4.
- R6: The enable register (address 7) holds one change-detect enable per pin in bits 3:0. Written bits 7:4 are ignored and read 0.
- R7: A change flag sets three clock edges after its pin changes, if that pin is enabled. A pin whose enable is 0 never sets its flag.
- R8: A read of address 6 returns the flags as they were before the read, then clears them. A change detected on the same edge as the clearing read survives.
- R9: Bit 3 of both channel nibbles is 1 whenever any change flag is set.
- R10: `irq_out` is registered. It is 1 one clock after any status bit and its mask bit are both 1, and 0 one clock after no such pair exists.
- R11: Writes to addresses 0, 1, 2 and 6 change neither the mask nor the change flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_tx_req | input | 2 | Transmit request per channel (bit 0 = A) |
| ch_rx_req | input | 2 | Receive request per channel |
| ch_brk_req | input | 2 | Break request per channel |
| pin_in | input | NUM_PINS | Asynchronous general input pins |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the clock after `reg_rd` |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
A wrong mask bit shows in two places. It appears through the other mask view on the next read, and it flips `irq_out` one clock after the matching source bit changes. A change flag that is lost, or that sets without its enable, shows on the next read of the pin-change register and in bit 3 of both status nibbles. It also shows on `irq_out` one clock later. The hardest case is a clearing read that lands on the same edge as a new change. The bench hits that edge exactly and expects the new flag to remain on the following read.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int NUM_CH   = 2;
  localparam int SRC_BITS = 4;
  localparam int DATA_W   = NUM_CH * SRC_BITS;
  localparam int ADDR_W   = 3;

  localparam int SRC_TX  = 0;
  localparam int SRC_RX  = 1;
  localparam int SRC_BRK = 2;
  localparam int SRC_PIN = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STAT_ALL = 3'd0,
    ADDR_STAT_A   = 3'd1,
    ADDR_STAT_B   = 3'd2,
    ADDR_MASK_ALL = 3'd3,
    ADDR_MASK_A   = 3'd4,
    ADDR_MASK_B   = 3'd5,
    ADDR_PIN_CHG  = 3'd6,
    ADDR_PIN_EN   = 3'd7
  } icc_addr_e;
endpackage

// File: rtl/icc_sync_vec.sv
module icc_sync_vec #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/icc_change_det.sv
module icc_change_det #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic                clr,
  output logic [NUM_PINS-1:0] set_vec,
  output logic [NUM_PINS-1:0] flags_q
);
  logic [NUM_PINS-1:0] prev_q;

  // The previous sample tracks every pin, enabled or not, so enabling
  // a pin later never reports a stale difference.
  assign set_vec = (pin_sync ^ prev_q) & pin_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flags_q <= '0;
    end else begin
      prev_q  <= pin_sync;
      // Set has priority over the read-clear so that no change is lost.
      flags_q <= (clr ? '0 : flags_q) | set_vec;
    end
  end
endmodule

// File: rtl/icc_regs.sv
module icc_regs
  import icc_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   status_all,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] chg_flags,
  output logic [DATA_W-1:0]   mask_q,
  output logic [NUM_PINS-1:0] en_q,
  output logic                chg_clr,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam int CHG_W = 2 * NUM_PINS;

  icc_addr_e           addr;
  logic [CHG_W-1:0]    chg_word;
  logic [DATA_W-1:0]   rd_mux;

  assign addr     = icc_addr_e'(reg_addr);
  assign chg_word = {chg_flags, pin_sync};
  assign chg_clr  = reg_rd && (addr == ADDR_PIN_CHG);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (reg_wr) begin
      case (addr)
        ADDR_MASK_ALL: mask_q <= reg_wdata;
        ADDR_MASK_A:   mask_q[SRC_BITS-1:0] <= reg_wdata[SRC_BITS-1:0];
        ADDR_MASK_B:   mask_q[DATA_W-1:SRC_BITS] <= reg_wdata[SRC_BITS-1:0];
        ADDR_PIN_EN:   en_q <= reg_wdata[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_STAT_ALL: rd_mux = status_all;
      ADDR_STAT_A:   rd_mux[SRC_BITS-1:0] = status_all[SRC_BITS-1:0];
      ADDR_STAT_B:   rd_mux[SRC_BITS-1:0] = status_all[DATA_W-1:SRC_BITS];
      ADDR_MASK_ALL: rd_mux = mask_q;
      ADDR_MASK_A:   rd_mux[SRC_BITS-1:0] = mask_q[SRC_BITS-1:0];
      ADDR_MASK_B:   rd_mux[SRC_BITS-1:0] = mask_q[DATA_W-1:SRC_BITS];
      ADDR_PIN_CHG:  rd_mux = DATA_W'(chg_word);
      ADDR_PIN_EN:   rd_mux[NUM_PINS-1:0] = en_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/icc_irq_merge.sv
module icc_irq_merge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] mask,
  output logic             irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(status & mask);
  end
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   ch_tx_req,
  input  logic [NUM_CH-1:0]   ch_rx_req,
  input  logic [NUM_CH-1:0]   ch_brk_req,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_out
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_en;
  logic [NUM_PINS-1:0] chg_flags;
  logic [NUM_PINS-1:0] chg_set;
  logic                chg_clr;
  logic                pin_any;
  logic [DATA_W-1:0]   status_all;
  logic [DATA_W-1:0]   mask_all;

  icc_sync_vec #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_sync)
  );

  icc_change_det #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .pin_en(pin_en),
    .clr(chg_clr), .set_vec(chg_set), .flags_q(chg_flags)
  );

  assign pin_any = |chg_flags;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign status_all[c*SRC_BITS + SRC_TX]  = ch_tx_req[c];
      assign status_all[c*SRC_BITS + SRC_RX]  = ch_rx_req[c];
      assign status_all[c*SRC_BITS + SRC_BRK] = ch_brk_req[c];
      assign status_all[c*SRC_BITS + SRC_PIN] = pin_any;
    end
  endgenerate

  icc_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_all(status_all),
    .pin_sync(pin_sync), .chg_flags(chg_flags), .mask_q(mask_all),
    .en_q(pin_en), .chg_clr(chg_clr), .reg_rdata(reg_rdata)
  );

  icc_irq_merge #(.WIDTH(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .status(status_all), .mask(mask_all),
    .irq_out(irq_out)
  );
endmodule

// File: rtl/icc_ctrl_chk.sv
module icc_ctrl_chk
  import icc_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [DATA_W-1:0]   reg_wdata,
  input logic                irq_out,
  input logic [DATA_W-1:0]   status_all,
  input logic [DATA_W-1:0]   mask_all,
  input logic [NUM_PINS-1:0] chg_flags,
  input logic [NUM_PINS-1:0] chg_set,
  input logic [NUM_PINS-1:0] chg_en
);
  assert_irq_high_R10: assert property (@(posedge clk) disable iff (rst)
    (|(status_all & mask_all)) |=> irq_out);

  assert_irq_low_R10: assert property (@(posedge clk) disable iff (rst)
    !(|(status_all & mask_all)) |=> !irq_out);

  assert_no_disabled_flag_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((chg_flags & ~$past(chg_flags) & ~$past(chg_en)) == '0));

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd6) |=> ((chg_flags & ~$past(chg_set)) == '0));

  assert_mask_view_a_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd4) |=>
      (mask_all[3:0] == $past(reg_wdata[3:0])) && $stable(mask_all[7:4]));

  assert_mask_view_b_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd5) |=>
      (mask_all[7:4] == $past(reg_wdata[3:0])) && $stable(mask_all[3:0]));

  assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1 || reg_addr == 3'd2 ||
                reg_addr == 3'd6)) |=> $stable(mask_all));
endmodule

bind icc_ctrl icc_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_out(irq_out),
  .status_all(status_all), .mask_all(mask_all), .chg_flags(chg_flags),
  .chg_set(chg_set), .chg_en(pin_en)
);

// File: tb/test_icc_ctrl.sv
module test_icc_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ch_tx_req = '0;
  logic [1:0] ch_rx_req = '0;
  logic [1:0] ch_brk_req = '0;
  logic [3:0] pin_in = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  icc_ctrl i_icc_ctrl (
    .clk(clk), .rst(rst), .ch_tx_req(ch_tx_req), .ch_rx_req(ch_rx_req),
    .ch_brk_req(ch_brk_req), .pin_in(pin_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Monitor: each accepted read produces one result the clock after.
  always @(posedge clk) begin
    if (reg_rd && !rst) begin
      #1;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read data %h", reg_rdata);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd_expect(input logic [2:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_addr = a;
    reg_rd   = 1'b1;
    @(negedge clk);
    reg_rd   = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd_expect(3'd3, 8'h00, "R1 mask reset");
    rd_expect(3'd7, 8'h00, "R1 enable reset");
    rd_expect(3'd6, 8'h00, "R1 flags reset");

    // R2 / R3 source layout
    ch_tx_req = 2'b01; ch_rx_req = 2'b10; ch_brk_req = 2'b10;
    idle(1);
    rd_expect(3'd0, 8'h61, "R2 combined status");
    rd_expect(3'd1, 8'h01, "R3 channel A status");
    rd_expect(3'd2, 8'h06, "R3 channel B status");
    chk_irq(1'b0, "R10 all masked");

    // R4 / R10 mask views
    wr(3'd3, 8'h20);
    idle(1);
    chk_irq(1'b1, "R10 rx B unmasked");
    rd_expect(3'd5, 8'h02, "R4 B view of combined write");
    rd_expect(3'd4, 8'h00, "R4 A view of combined write");
    wr(3'd4, 8'hFF);
    rd_expect(3'd3, 8'h2F, "R4 combined after A view write");
    wr(3'd5, 8'h00);
    rd_expect(3'd3, 8'h0F, "R4 combined after B view write");
    idle(1);
    chk_irq(1'b1, "R10 tx A unmasked");
    ch_tx_req = '0; ch_rx_req = '0; ch_brk_req = '0;
    idle(2);
    chk_irq(1'b0, "R10 sources dropped");

    // R11 writes to read-only addresses
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd6, 8'hFF);
    rd_expect(3'd3, 8'h0F, "R11 mask unchanged");
    rd_expect(3'd6, 8'h00, "R11 flags unchanged");

    // R6 enable register
    wr(3'd7, 8'hF5);
    rd_expect(3'd7, 8'h05, "R6 enable upper bits ignored");

    // R7 / R9 / R5 / R8 change detection
    pin_in = 4'b0011;
    idle(5);
    rd_expect(3'd0, 8'h88, "R9 change bit in both channels");
    chk_irq(1'b1, "R10 change unmasked");
    rd_expect(3'd6, 8'h13, "R5 R7 pin0 flag only");
    rd_expect(3'd6, 8'h03, "R8 flags cleared by read");
    idle(1);
    chk_irq(1'b0, "R10 after flag clear");

    // R8 clearing read on the same edge a new change is detected
    pin_in = 4'b0111;
    idle(2);
    rd_expect(3'd6, 8'h07, "R8 read at detect edge");
    rd_expect(3'd6, 8'h47, "R8 coincident change kept");
    rd_expect(3'd6, 8'h07, "R8 cleared afterwards");

    // R7 disabled pin falling
    pin_in = 4'b0101;
    idle(5);
    rd_expect(3'd6, 8'h05, "R7 disabled pin no flag");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule